// File: doc/BRIEF.md
# Frame Slip Elastic Buffer

This block is a bit-serial elastic store between a line-side writer and a system-bus reader, both given as enables of one shared clock. Payload arrives one bit per write enable, with a write frame pulse on the first bit of each frame. It leaves one bit per read enable, with a read frame pulse on the first bit of each outgoing frame. The frame length is a build parameter: 193 bits (T1, with one overhead bit and 24 channels) or 256 bits (E1, 32 time slots).

A runtime depth select gives three modes. In bypass mode the buffer is skipped. In two-frame mode, when the pointers drift too close, the read pointer moves by exactly one frame, so a whole frame is repeated or dropped and alignment is kept. In short mode the store is 64 bits deep and a slip cannot line up with a frame. Sticky flags record the direction of each slip, and a separate flag records slips in short mode. A phase output gives the write-minus-read distance. Read data of any selected time slot can be replaced by an 8-bit idle code.

Top module: `frame_slip_buffer`

## Requirements
- R1: While `rst_ni` is low, all flags and `rd_bit_o` go to 0. The read pointer starts one frame behind the writer, so `phase_o` is FRAME_BITS in two-frame mode (`depth_sel_i`=1), 32 in short mode (`depth_sel_i`=2), and 0 in bypass (`depth_sel_i`=0 or 3). The mode is changed only while in reset.
- R2: In two-frame mode, with no slip, bits come out in the order they were written. `rd_bit_o` takes the new bit on the clock edge that samples `rd_en_i`, and holds it otherwise. Equal read and write rates never cause a slip.
- R3: In two-frame mode the slip test is made only on a read whose frame position is 0. Let d = (write pointer − read frame start) mod 2·FRAME_BITS. If d < FRAME_BITS/4, the read moves back one frame (that frame is repeated) and `slip_rep_o` is set.
- R4: Under the same test, if d > 2·FRAME_BITS − FRAME_BITS/4, the read moves forward one frame (a frame is deleted) and `slip_del_o` is set.
- R5: The slip flags are sticky. A `slip_ack_i` pulse clears them, but a slip in the same cycle keeps its flag set.
- R6: `phase_o` is (write pointer − read pointer) modulo the active depth, both pointers being the next addresses to use. It changes only after an enabled write or read.
- R7: In short mode (64 bits), every read checks d = (write − read) mod 64. If d < 4 the read pointer moves back by 32 and `slip_rep_o` is set; if d > 60 it moves forward by 32 and `slip_del_o` is set. Either case also sets `uslip_o`, which is set in no other mode.
- R8: In bypass mode each read registers `wr_bit_i` directly. No slip flag is ever set and `phase_o` stays 0.
- R9: Idle code insertion applies in every mode. If the bit read sits in time slot s and `idle_mask_i[s]` is 1, the output is `idle_code_i[7-k]`, where k is the bit index within the slot (MSB first). For a 193-bit frame, position 0 is the overhead bit and is never replaced, and position p≥1 lies in slot (p−1)/8. For a 256-bit frame, slot = p/8.
- R10: A frame pulse with an enable sets that side's frame position to 0. If it arrives mid-frame in two-frame mode, the pointer goes to the start of the other frame half before the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | shared clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| depth_sel_i | input | 2 | 0 bypass, 1 two-frame, 2 short 64-bit, 3 bypass |
| wr_en_i | input | 1 | line-side bit strobe |
| wr_sync_i | input | 1 | first bit of a written frame |
| wr_bit_i | input | 1 | written data bit |
| rd_en_i | input | 1 | system-side bit strobe |
| rd_sync_i | input | 1 | first bit of a read frame |
| idle_mask_i | input | FRAME_BITS/8 | per-slot idle substitution enable |
| idle_code_i | input | 8 | idle code, MSB sent first |
| slip_ack_i | input | 1 | clears sticky slip flags |
| rd_bit_o | output | 1 | read data bit, registered |
| slip_rep_o | output | 1 | sticky: frame repeated |
| slip_del_o | output | 1 | sticky: frame deleted |
| uslip_o | output | 1 | sticky: slip in short mode |
| phase_o | output | clog2(2·FRAME_BITS) | write-to-read pointer distance |

## Verification
A read pointer that is off by even one position shows on `phase_o` one cycle after the next enabled access, and on `rd_bit_o` as soon as the two buffer halves hold different data. A slip at the wrong moment is worse: the pointer jumps a whole frame, so a random payload stream gives the wrong bit on the very next read, and the sticky flag rises or stays low against prediction. A wrong slot or bit-index decode in the idle stage shows on the first replaced bit of the first frame read with a mask set.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [1:0] {
    DEPTH_BYPASS    = 2'd0,
    DEPTH_TWO_FRAME = 2'd1,
    DEPTH_SHORT     = 2'd2,
    DEPTH_RSVD      = 2'd3
  } depth_e;
endpackage

// File: rtl/fes_wr_ptr.sv
module fes_wr_ptr #(
  parameter int FRAME_BITS = 193,
  parameter int SHORT_BITS = 64,
  localparam int AW = $clog2(2*FRAME_BITS),
  localparam int SW = $clog2(SHORT_BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          sync_i,
  output logic [AW-1:0] frame_addr_o,
  output logic [AW-1:0] frame_ptr_o,
  output logic [SW-1:0] short_ptr_o
);
  localparam int PW = $clog2(FRAME_BITS);
  localparam logic [AW-1:0] FL   = AW'(FRAME_BITS);
  localparam logic [AW-1:0] LAST = AW'(2*FRAME_BITS-1);
  localparam logic [PW-1:0] PLAST = PW'(FRAME_BITS-1);

  logic [AW-1:0] lin_q, base;
  logic [PW-1:0] pos_q, pos_eff;
  logic [SW-1:0] s_q;

  always_comb begin
    pos_eff = sync_i ? '0 : pos_q;
    // mid-frame pulse: restart at the other half
    base = (sync_i && pos_q != '0) ? ((lin_q < FL) ? FL : '0) : lin_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lin_q <= FL;
      pos_q <= '0;
      s_q   <= SW'(SHORT_BITS/2);
    end else if (en_i) begin
      lin_q <= (base == LAST) ? '0 : base + AW'(1);
      pos_q <= (pos_eff == PLAST) ? '0 : pos_eff + PW'(1);
      s_q   <= s_q + SW'(1);
    end
  end

  assign frame_addr_o = base;
  assign frame_ptr_o  = lin_q;
  assign short_ptr_o  = s_q;
endmodule

// File: rtl/fes_rd_ptr.sv
module fes_rd_ptr #(
  parameter int FRAME_BITS  = 193,
  parameter int SHORT_BITS  = 64,
  parameter int SHORT_GUARD = 4,
  localparam int AW = $clog2(2*FRAME_BITS),
  localparam int SW = $clog2(SHORT_BITS),
  localparam int PW = $clog2(FRAME_BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          sync_i,
  input  logic          two_frame_i,
  input  logic          short_i,
  input  logic [AW-1:0] wr_frame_ptr_i,
  input  logic [SW-1:0] wr_short_ptr_i,
  output logic [AW-1:0] frame_addr_o,
  output logic [SW-1:0] short_addr_o,
  output logic [AW-1:0] frame_ptr_o,
  output logic [SW-1:0] short_ptr_o,
  output logic [PW-1:0] pos_o,
  output logic          slip_rep_o,
  output logic          slip_del_o
);
  localparam int LOW  = FRAME_BITS/4;
  localparam int HIGH = 2*FRAME_BITS - LOW;
  localparam logic [AW-1:0] FL   = AW'(FRAME_BITS);
  localparam logic [AW-1:0] BUF  = AW'(2*FRAME_BITS);
  localparam logic [AW-1:0] LAST = AW'(2*FRAME_BITS-1);
  localparam logic [PW-1:0] PLAST = PW'(FRAME_BITS-1);
  localparam logic [SW-1:0] HALF  = SW'(SHORT_BITS/2);

  logic [AW-1:0] lin_q, base, dist_f, flip, fr_eff;
  logic [PW-1:0] pos_q, pos_eff;
  logic [SW-1:0] s_q, dist_s, s_eff;
  logic at_start, f_rep, f_del, s_chk, s_rep, s_del;

  always_comb begin
    pos_eff  = sync_i ? '0 : pos_q;
    base     = (sync_i && pos_q != '0) ? ((lin_q < FL) ? FL : '0) : lin_q;
    dist_f   = (wr_frame_ptr_i >= base) ? wr_frame_ptr_i - base
                                        : wr_frame_ptr_i + BUF - base;
    at_start = en_i && two_frame_i && (pos_eff == '0);
    f_rep    = at_start && (dist_f < AW'(LOW));
    f_del    = at_start && (dist_f > AW'(HIGH));
    flip     = (base < FL) ? base + FL : base - FL;
    fr_eff   = (f_rep || f_del) ? flip : base;
    dist_s   = wr_short_ptr_i - s_q;
    s_chk    = en_i && short_i;
    s_rep    = s_chk && (dist_s < SW'(SHORT_GUARD));
    s_del    = s_chk && (dist_s > SW'(SHORT_BITS-SHORT_GUARD));
    s_eff    = (s_rep || s_del) ? (s_q ^ HALF) : s_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lin_q <= '0;
      pos_q <= '0;
      s_q   <= '0;
    end else if (en_i) begin
      lin_q <= (fr_eff == LAST) ? '0 : fr_eff + AW'(1);
      pos_q <= (pos_eff == PLAST) ? '0 : pos_eff + PW'(1);
      s_q   <= s_eff + SW'(1);
    end
  end

  assign frame_addr_o = fr_eff;
  assign short_addr_o = s_eff;
  assign frame_ptr_o  = lin_q;
  assign short_ptr_o  = s_q;
  assign pos_o        = pos_eff;
  assign slip_rep_o   = f_rep || s_rep;
  assign slip_del_o   = f_del || s_del;
endmodule

// File: rtl/fes_idle_sub.sv
module fes_idle_sub #(
  parameter int FRAME_BITS = 193,
  localparam int PW    = $clog2(FRAME_BITS),
  localparam int SLOTS = FRAME_BITS/8
) (
  input  logic [PW-1:0]    pos_i,
  input  logic [SLOTS-1:0] mask_i,
  input  logic [7:0]       code_i,
  input  logic             bit_i,
  output logic             bit_o
);
  logic [PW-1:0] ts_pos;
  logic          ovh;
  logic [PW-4:0] slot;
  logic [2:0]    idx;

  if (FRAME_BITS % 8 != 0) begin : g_ovh_bit
    assign ts_pos = pos_i - PW'(1);
    assign ovh    = (pos_i == '0);
  end else begin : g_no_ovh
    assign ts_pos = pos_i;
    assign ovh    = 1'b0;
  end

  assign slot  = ts_pos[PW-1:3];
  assign idx   = ts_pos[2:0];
  assign bit_o = (!ovh && mask_i[slot]) ? code_i[3'd7 - idx] : bit_i;
endmodule

// File: rtl/frame_slip_buffer.sv
module frame_slip_buffer
  import fes_pkg::*;
#(
  parameter int FRAME_BITS  = 193,
  parameter int SHORT_BITS  = 64,
  parameter int SHORT_GUARD = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [1:0]                        depth_sel_i,
  input  logic                              wr_en_i,
  input  logic                              wr_sync_i,
  input  logic                              wr_bit_i,
  input  logic                              rd_en_i,
  input  logic                              rd_sync_i,
  input  logic [FRAME_BITS/8-1:0]           idle_mask_i,
  input  logic [7:0]                        idle_code_i,
  input  logic                              slip_ack_i,
  output logic                              rd_bit_o,
  output logic                              slip_rep_o,
  output logic                              slip_del_o,
  output logic                              uslip_o,
  output logic [$clog2(2*FRAME_BITS)-1:0]   phase_o
);
  localparam int BUF_BITS = 2*FRAME_BITS;
  localparam int AW = $clog2(BUF_BITS);
  localparam int SW = $clog2(SHORT_BITS);
  localparam int PW = $clog2(FRAME_BITS);

  depth_e depth;
  logic two_frame, short_mode, bypass;
  assign depth      = depth_e'(depth_sel_i);
  assign two_frame  = (depth == DEPTH_TWO_FRAME);
  assign short_mode = (depth == DEPTH_SHORT);
  assign bypass     = !two_frame && !short_mode;

  logic [AW-1:0] w_faddr, w_fptr, r_faddr, r_fptr, wr_addr, rd_addr;
  logic [SW-1:0] w_sptr, r_saddr, r_sptr;
  logic [PW-1:0] r_pos;
  logic rep_p, del_p, raw_bit, sub_bit;

  fes_wr_ptr #(.FRAME_BITS(FRAME_BITS), .SHORT_BITS(SHORT_BITS)) u_wr (
    .clk_i, .rst_ni, .en_i(wr_en_i), .sync_i(wr_sync_i),
    .frame_addr_o(w_faddr), .frame_ptr_o(w_fptr), .short_ptr_o(w_sptr));

  fes_rd_ptr #(.FRAME_BITS(FRAME_BITS), .SHORT_BITS(SHORT_BITS),
               .SHORT_GUARD(SHORT_GUARD)) u_rd (
    .clk_i, .rst_ni, .en_i(rd_en_i), .sync_i(rd_sync_i),
    .two_frame_i(two_frame), .short_i(short_mode),
    .wr_frame_ptr_i(w_fptr), .wr_short_ptr_i(w_sptr),
    .frame_addr_o(r_faddr), .short_addr_o(r_saddr),
    .frame_ptr_o(r_fptr), .short_ptr_o(r_sptr), .pos_o(r_pos),
    .slip_rep_o(rep_p), .slip_del_o(del_p));

  assign wr_addr = short_mode ? AW'(w_sptr)  : w_faddr;
  assign rd_addr = short_mode ? AW'(r_saddr) : r_faddr;

  logic [BUF_BITS-1:0] mem_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                mem_q <= '0;
    else if (wr_en_i && !bypass) mem_q[wr_addr] <= wr_bit_i;
  end

  assign raw_bit = bypass ? wr_bit_i : mem_q[rd_addr];

  fes_idle_sub #(.FRAME_BITS(FRAME_BITS)) u_idle (
    .pos_i(r_pos), .mask_i(idle_mask_i), .code_i(idle_code_i),
    .bit_i(raw_bit), .bit_o(sub_bit));

  logic rd_bit_q, rep_q, del_q, unc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_bit_q <= 1'b0;
      rep_q    <= 1'b0;
      del_q    <= 1'b0;
      unc_q    <= 1'b0;
    end else begin
      if (rd_en_i) rd_bit_q <= sub_bit;
      rep_q <= (rep_q && !slip_ack_i) || rep_p;
      del_q <= (del_q && !slip_ack_i) || del_p;
      unc_q <= (unc_q && !slip_ack_i) || (short_mode && (rep_p || del_p));
    end
  end

  always_comb begin
    if (two_frame)
      phase_o = (w_fptr >= r_fptr) ? w_fptr - r_fptr
                                   : w_fptr + AW'(BUF_BITS) - r_fptr;
    else if (short_mode)
      phase_o = AW'(SW'(w_sptr - r_sptr));
    else
      phase_o = '0;
  end

  assign rd_bit_o   = rd_bit_q;
  assign slip_rep_o = rep_q;
  assign slip_del_o = del_q;
  assign uslip_o    = unc_q;
endmodule

// File: rtl/fes_chk.sv
module fes_chk #(
  parameter int FRAME_BITS = 193,
  parameter int SHORT_BITS = 64
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [1:0]                      depth_sel_i,
  input logic                            wr_en_i,
  input logic                            rd_en_i,
  input logic                            slip_ack_i,
  input logic                            slip_rep_o,
  input logic                            slip_del_o,
  input logic                            uslip_o,
  input logic [$clog2(2*FRAME_BITS)-1:0] phase_o
);
  AST_PHASE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_sel_i == 2'd1) |-> (int'(phase_o) < 2*FRAME_BITS)); // R6
  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !rd_en_i) |=> $stable(phase_o)); // R6
  AST_REP_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slip_rep_o) |-> $past(rd_en_i)); // R3
  AST_DEL_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slip_del_o) |-> $past(rd_en_i)); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slip_ack_i && !rd_en_i) |=> !(slip_rep_o || slip_del_o || uslip_o)); // R5
  AST_UNC_SHORT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uslip_o |-> (depth_sel_i == 2'd2)); // R7
  AST_SHORT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_sel_i == 2'd2) |-> (int'(phase_o) < SHORT_BITS)); // R7
  AST_BYPASS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_sel_i == 2'd0) |-> (phase_o == '0 && !slip_rep_o && !slip_del_o)); // R8
endmodule

bind frame_slip_buffer fes_chk #(.FRAME_BITS(FRAME_BITS), .SHORT_BITS(SHORT_BITS)) u_fes_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .depth_sel_i(depth_sel_i),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .slip_ack_i(slip_ack_i),
  .slip_rep_o(slip_rep_o), .slip_del_o(slip_del_o), .uslip_o(uslip_o),
  .phase_o(phase_o));

// File: tb/sim_frame_slip_buffer.sv
module sim_frame_slip_buffer;
  localparam int FL    = 193;
  localparam int BUF   = 2*FL;
  localparam int LOW   = FL/4;
  localparam int HIGH  = BUF - LOW;
  localparam int SLOTS = FL/8;
  localparam int AW    = $clog2(BUF);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_ni = 1'b0;
  logic [1:0] depth_sel = 2'd1;
  logic wr_en = 0, wr_sync = 0, wr_bit = 0, rd_en = 0, rd_sync = 0, ack = 0;
  logic [SLOTS-1:0] idle_mask = '0;
  logic [7:0] idle_code = '0;
  logic rd_bit, s_rep, s_del, s_unc;
  logic [AW-1:0] phase;

  frame_slip_buffer #(.FRAME_BITS(FL)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .depth_sel_i(depth_sel),
    .wr_en_i(wr_en), .wr_sync_i(wr_sync), .wr_bit_i(wr_bit),
    .rd_en_i(rd_en), .rd_sync_i(rd_sync),
    .idle_mask_i(idle_mask), .idle_code_i(idle_code), .slip_ack_i(ack),
    .rd_bit_o(rd_bit), .slip_rep_o(s_rep), .slip_del_o(s_del),
    .uslip_o(s_unc), .phase_o(phase));

  int n_vec = 0, n_bad = 0;
  string tag = "R1";

  bit m_mem[BUF];
  int m_wl, m_wpos, m_ws, m_rl, m_rpos, m_rs, mode;
  bit m_rep, m_del, m_unc, m_out;

  task automatic chk(string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_phase();
    if (mode == 1) return (m_wl - m_rl + BUF) % BUF;
    if (mode == 2) return (m_ws - m_rs + 64) % 64;
    return 0;
  endfunction

  function automatic bit idle_bit(int pos, bit raw);
    int t;
    if (FL % 8 != 0) begin
      if (pos == 0) return raw;
      t = pos - 1;
    end else t = pos;
    if (idle_mask[t/8]) return idle_code[7 - (t%8)];
    return raw;
  endfunction

  task automatic compare_all();
    chk("rd_bit", rd_bit, m_out);
    chk("slip_rep", s_rep, m_rep);
    chk("slip_del", s_del, m_del);
    chk("uslip", s_unc, m_unc);
    chk("phase", phase, exp_phase());
  endtask

  task automatic model_step(bit wen, bit wsy, bit wb, bit ren, bit rsy, bit ak);
    int base, sb, rpe, d, wbase, wpe;
    bit rep = 0, del = 0, unc = 0, raw;
    if (ren) begin
      rpe  = rsy ? 0 : m_rpos;
      base = (rsy && m_rpos != 0) ? (m_rl < FL ? FL : 0) : m_rl;
      sb   = m_rs;
      if (mode == 1 && rpe == 0) begin
        d = (m_wl - base + BUF) % BUF;
        if (d < LOW) rep = 1; else if (d > HIGH) del = 1;
        if (rep || del) base = (base + FL) % BUF;
      end
      if (mode == 2) begin
        d = (m_ws - m_rs + 64) % 64;
        if (d < 4) begin rep = 1; unc = 1; end
        else if (d > 60) begin del = 1; unc = 1; end
        if (unc) sb = sb ^ 32;
      end
      raw   = (mode == 0) ? wb : m_mem[(mode == 2) ? sb : base];
      m_out = idle_bit(rpe, raw);
      m_rl  = (base + 1) % BUF;
      m_rs  = (sb + 1) % 64;
      m_rpos = (rpe + 1) % FL;
    end
    m_rep = (m_rep && !ak) || rep;
    m_del = (m_del && !ak) || del;
    m_unc = (m_unc && !ak) || unc;
    if (wen) begin
      wpe   = wsy ? 0 : m_wpos;
      wbase = (wsy && m_wpos != 0) ? (m_wl < FL ? FL : 0) : m_wl;
      if (mode != 0) m_mem[(mode == 2) ? m_ws : wbase] = wb;
      m_wl   = (wbase + 1) % BUF;
      m_ws   = (m_ws + 1) % 64;
      m_wpos = (wpe + 1) % FL;
    end
  endtask

  task automatic step(bit wen, bit wb, bit ren, bit force_rsync, bit ak);
    bit wsy, rsy;
    wsy = wen && (m_wpos == 0);
    rsy = ren && (force_rsync || m_rpos == 0);
    wr_en = wen; wr_sync = wsy; wr_bit = wb;
    rd_en = ren; rd_sync = rsy; ack = ak;
    model_step(wen, wsy, wb, ren, rsy, ak);
    @(negedge clk);
    compare_all();
  endtask

  task automatic run(int n, int pw, int pr);
    for (int i = 0; i < n; i++)
      step(($urandom % 100) < pw, 1'($urandom), ($urandom % 100) < pr, 1'b0, 1'b0);
  endtask

  task automatic do_reset(int md);
    rst_ni = 1'b0; depth_sel = 2'(md);
    wr_en = 0; wr_sync = 0; rd_en = 0; rd_sync = 0; ack = 0;
    repeat (2) @(negedge clk);
    mode = md;
    foreach (m_mem[i]) m_mem[i] = 1'b0;
    m_wl = FL; m_rl = 0; m_wpos = 0; m_rpos = 0; m_ws = 32; m_rs = 0;
    m_rep = 0; m_del = 0; m_unc = 0; m_out = 0;
    rst_ni = 1'b1;
    tag = "R1";
    chk("reset phase", phase, (md == 1) ? FL : (md == 2) ? 32 : 0);
    chk("reset flags", {s_rep, s_del, s_unc, rd_bit}, 0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset(1);

    tag = "R2";
    run(600, 100, 100);
    chk("R2 no slip at equal rate", s_rep || s_del, 0);

    tag = "R6";
    run(800, 70, 70);

    tag = "R4";
    run(3000, 100, 88);
    chk("R4 delete seen", s_del, 1);

    tag = "R5";
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R5 ack cleared", {s_rep, s_del, s_unc}, 0);

    tag = "R3";
    run(3000, 88, 100);
    chk("R3 repeat seen", s_rep, 1);

    tag = "R9";
    idle_mask = SLOTS'($urandom); idle_code = 8'($urandom);
    run(800, 100, 100);
    idle_mask = '1; idle_code = 8'hA5;
    run(400, 100, 100);
    idle_mask = '0;

    tag = "R10";
    while (m_rpos != 77) step(1'b1, 1'($urandom), 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'($urandom), 1'b1, 1'b1, 1'b0);
    run(400, 100, 100);

    tag = "R7";
    do_reset(2);
    tag = "R7";
    run(1000, 100, 90);
    chk("R7 uncontrolled delete", {s_unc, s_del}, 3);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    run(1000, 90, 100);
    chk("R7 uncontrolled repeat", {s_unc, s_rep}, 3);

    do_reset(0);
    tag = "R8";
    run(800, 60, 60);
    chk("R8 bypass no flags", {s_rep, s_del, s_unc}, 0);

    summary();
    $finish;
  end
endmodule